// File: doc/BRIEF.md
# Pixel Depth Mode Selector

This block sits on the register side of a graphics controller and settles how many bits each pixel occupies. It holds three registers: a sequencer extended-mode register, which carries an extended-graphics enable and a pixel-format field, and the graphics mode and graphics extension registers. It also holds a hidden palette-DAC control register. Software cannot address the hidden register directly. It reaches it by reading the DAC mask port four times in a row and then writing the mask port. That write goes to the hidden register instead of the mask.

Each write to the hidden register re-evaluates the pixel depth from the sequencer format field. The hidden register's bit 0 picks between 15 and 16 bits for the two 16-bit field codes. The block reports the depth as a plain number (8, 15, 16, 24 or 32). It raises a row-offset doubling flag for 32-bit extended modes. It also decodes the graphics mode register into read mode, chain-2 read flag and write mode, and the write mode's width depends on an enable bit in the graphics extension register. While extended graphics is on, the block repairs a graphics mode register whose bits 6:5 are both zero by loading 0x60.

Top module: `pixdepth_sel`

## Requirements
- R1: After reset the following outputs hold: `depth_bpp` = 8, `write_mode` = 0, `read_mode` = 0, `chain2_rd` = 0, `row_dbl` = 0, `gfx_mode` = 0x00 and `dac_ctrl` = 0x00.
- R2: An access takes effect at the rising edge where `acc_valid` is 1. The `acc_target` codes are: 0 sequencer extended register, 1 graphics mode register, 2 graphics extension register, 3 DAC mask port, 4 other DAC port. Codes 5 to 7 have no effect.
- R3: Reads of the mask port are counted. Each read (`acc_write` = 0, target 3) advances an access count that saturates at 4. A write to the mask port loads `acc_data` into `dac_ctrl` only when the count is 4.
- R4: Every mask-port write returns the count to 0, whether or not it reached the hidden register. Any access to target 4 (read or write) also returns the count to 0. Accesses to targets 0, 1 and 2 leave the count unchanged.
- R5: A hidden-register write sets `depth_bpp` from the sequencer register's bits 3:1 as they stand before that edge. Code 000 gives 8, code 010 gives 24 and code 100 gives 32.
- R6: The field codes 001 (16 bpp, doubled clock) and 011 (16 bpp) give depth 16 when bit 0 of the written hidden value is 1. They give depth 15 when that bit is 0.
- R7: `depth_bpp` changes only on a hidden-register write. Field codes 101, 110 and 111 leave it unchanged, and sequencer writes alone never change it.
- R8: When sequencer bit 0 (extended enable) is 1 and the graphics mode register has bits 6:5 both 0, the register is loaded with 0x60 at the next edge, unless that edge writes the register.
- R9: `row_dbl` is 1 exactly when sequencer bit 0 is 1 and `depth_bpp` is 32.
- R10: When bit 2 of the graphics extension register is 1, `write_mode` equals graphics mode bits 2:0. Otherwise it equals {0, graphics mode bits 1:0}.
- R11: `read_mode` equals graphics mode bit 3 and `chain2_rd` equals graphics mode bit 4. `gfx_mode` shows the stored graphics mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_target | input | 3 | Access target code (see R2) |
| acc_data | input | 8 | Write data |
| depth_bpp | output | 6 | Active bits per pixel |
| row_dbl | output | 1 | Row offset doubling flag |
| read_mode | output | 1 | Decoded read mode |
| chain2_rd | output | 1 | Decoded chain-2 read flag |
| write_mode | output | 3 | Decoded write mode |
| gfx_mode | output | 8 | Stored graphics mode register |
| dac_ctrl | output | 8 | Hidden DAC control register |

## Verification
The access count is invisible at the ports. A wrong count shows only when the next mask-port write lands in, or misses, `dac_ctrl`, and that can happen many cycles after the faulty read or clearing access. The stimulus therefore mixes long runs of mask reads with stray accesses to the other DAC port and to the other registers. A wrong depth latch shows in `depth_bpp` one edge after the hidden write. Errors in the repair path or the decode show in `gfx_mode` and `write_mode` within one or two edges.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    localparam int REG_W = 8;
    localparam int BPP_W = 6;

    typedef enum logic [2:0] {
        TGT_SEQ_EXT  = 3'd0,
        TGT_GFX_MODE = 3'd1,
        TGT_GFX_EXT  = 3'd2,
        TGT_DAC_MASK = 3'd3,
        TGT_DAC_AUX  = 3'd4
    } tgt_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [2:0]       target;
        logic [REG_W-1:0] data;
    } acc_t;

    localparam logic [BPP_W-1:0] BPP_8  = 6'd8;
    localparam logic [BPP_W-1:0] BPP_15 = 6'd15;
    localparam logic [BPP_W-1:0] BPP_16 = 6'd16;
    localparam logic [BPP_W-1:0] BPP_24 = 6'd24;
    localparam logic [BPP_W-1:0] BPP_32 = 6'd32;

    localparam logic [2:0] FMT_8      = 3'b000;
    localparam logic [2:0] FMT_16DCLK = 3'b001;
    localparam logic [2:0] FMT_24     = 3'b010;
    localparam logic [2:0] FMT_16     = 3'b011;
    localparam logic [2:0] FMT_32     = 3'b100;

    function automatic logic acc_hits(input acc_t a, input tgt_e t, input logic wr);
        return a.valid && (a.write == wr) && (a.target == t);
    endfunction

    function automatic logic [BPP_W-1:0] pick_depth(
        input logic [2:0]       fmt,
        input logic             wide16,
        input logic [BPP_W-1:0] prev
    );
        logic [BPP_W-1:0] d;
        case (fmt)
            FMT_8:               d = BPP_8;
            FMT_16DCLK, FMT_16:  d = wide16 ? BPP_16 : BPP_15;
            FMT_24:              d = BPP_24;
            FMT_32:              d = BPP_32;
            default:             d = prev;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dac_hidden_seq.sv
module dac_hidden_seq
    import pdm_pkg::*;
#(
    parameter int UNLOCK_CNT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    output logic             hid_wr,
    output logic [REG_W-1:0] hid_data,
    output logic [REG_W-1:0] ctrl_q
);
    localparam int CNT_W = $clog2(UNLOCK_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(UNLOCK_CNT);

    logic [CNT_W-1:0] cnt_q;
    logic             mask_rd, mask_wr, aux_any;

    always_comb begin
        mask_rd  = acc_hits(acc, TGT_DAC_MASK, 1'b0);
        mask_wr  = acc_hits(acc, TGT_DAC_MASK, 1'b1);
        aux_any  = acc.valid && (acc.target == TGT_DAC_AUX);
        hid_wr   = mask_wr && (cnt_q == CNT_TOP);
        hid_data = acc.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (mask_wr || aux_any) begin
            cnt_q <= '0;
        end else if (mask_rd && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (hid_wr)
            ctrl_q <= hid_data;
    end

endmodule

// File: rtl/depth_eval.sv
module depth_eval
    import pdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hid_wr,
    input  logic [REG_W-1:0] hid_data,
    input  logic [2:0]       fmt,
    output logic [BPP_W-1:0] depth_q
);
    logic [BPP_W-1:0] depth_nx;

    always_comb begin
        depth_nx = pick_depth(fmt, hid_data[0], depth_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            depth_q <= BPP_8;
        else if (hid_wr)
            depth_q <= depth_nx;
    end

endmodule

// File: rtl/gfx_mode_dec.sv
module gfx_mode_dec
    import pdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic             ext_en,
    output logic [REG_W-1:0] mode_q,
    output logic [REG_W-1:0] ext_q,
    output logic             rd_mode,
    output logic             ch2_rd,
    output logic [2:0]       wr_mode
);
    localparam logic [REG_W-1:0] MODE_REPAIR = 8'h60;

    logic mode_wr, ext_wr, need_fix;

    always_comb begin
        mode_wr  = acc_hits(acc, TGT_GFX_MODE, 1'b1);
        ext_wr   = acc_hits(acc, TGT_GFX_EXT, 1'b1);
        need_fix = ext_en && (mode_q[6:5] == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= acc.data;
        else if (need_fix)
            mode_q <= MODE_REPAIR;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ext_q <= '0;
        else if (ext_wr)
            ext_q <= acc.data;
    end

    always_comb begin
        rd_mode = mode_q[3];
        ch2_rd  = mode_q[4];
        wr_mode = ext_q[2] ? mode_q[2:0] : {1'b0, mode_q[1:0]};
    end

endmodule

// File: rtl/pixdepth_sel.sv
module pixdepth_sel
    import pdm_pkg::*;
#(
    parameter int UNLOCK_CNT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [2:0] acc_target,
    input  logic [7:0] acc_data,
    output logic [5:0] depth_bpp,
    output logic       row_dbl,
    output logic       read_mode,
    output logic       chain2_rd,
    output logic [2:0] write_mode,
    output logic [7:0] gfx_mode,
    output logic [7:0] dac_ctrl
);
    acc_t             acc;
    logic [REG_W-1:0] seq_q;
    logic [REG_W-1:0] gfx_ext_q;
    logic             hid_wr;
    logic [REG_W-1:0] hid_data;
    logic [BPP_W-1:0] depth_q;

    always_comb begin
        acc.valid  = acc_valid;
        acc.write  = acc_write;
        acc.target = acc_target;
        acc.data   = acc_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            seq_q <= '0;
        else if (acc_hits(acc, TGT_SEQ_EXT, 1'b1))
            seq_q <= acc.data;
    end

    dac_hidden_seq #(.UNLOCK_CNT(UNLOCK_CNT)) u_dac (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .hid_wr   (hid_wr),
        .hid_data (hid_data),
        .ctrl_q   (dac_ctrl)
    );

    depth_eval u_depth (
        .clk      (clk),
        .rst      (rst),
        .hid_wr   (hid_wr),
        .hid_data (hid_data),
        .fmt      (seq_q[3:1]),
        .depth_q  (depth_q)
    );

    gfx_mode_dec u_gfx (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .ext_en  (seq_q[0]),
        .mode_q  (gfx_mode),
        .ext_q   (gfx_ext_q),
        .rd_mode (read_mode),
        .ch2_rd  (chain2_rd),
        .wr_mode (write_mode)
    );

    always_comb begin
        depth_bpp = depth_q;
        row_dbl   = seq_q[0] && (depth_q == BPP_32);
    end

endmodule

// File: rtl/pdm_checker.sv
module pdm_checker (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       acc_write,
    input logic [2:0] acc_target,
    input logic [7:0] seq_q,
    input logic [7:0] gfx_ext_q,
    input logic [5:0] depth_bpp,
    input logic       row_dbl,
    input logic [2:0] write_mode,
    input logic [7:0] gfx_mode,
    input logic [7:0] dac_ctrl
);
    // R3: the hidden register only moves after a mask-port write
    assert_hidden_src_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_ctrl) |-> $past(acc_valid && acc_write && acc_target == 3'd3));

    // R5 / R6: only the five legal depths appear
    assert_depth_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (depth_bpp == 6'd8) || (depth_bpp == 6'd15) || (depth_bpp == 6'd16) ||
        (depth_bpp == 6'd24) || (depth_bpp == 6'd32));

    // R7: depth moves only after a mask-port write
    assert_depth_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(depth_bpp) |-> $past(acc_valid && acc_write && acc_target == 3'd3));

    // R8: repair of an empty mode field
    assert_mode_repair_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_q[0] && gfx_mode[6:5] == 2'b00 && !(acc_valid && acc_write && acc_target == 3'd1))
        |=> gfx_mode == 8'h60);

    // R9: doubling implies 32-bit depth
    assert_row_dbl_R9: assert property (@(posedge clk) disable iff (rst)
        row_dbl |-> (depth_bpp == 6'd32));

    // R10: narrow write mode without the extension bit
    assert_wmode_width_R10: assert property (@(posedge clk) disable iff (rst)
        !gfx_ext_q[2] |-> !write_mode[2]);

endmodule

bind pixdepth_sel pdm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_target (acc_target),
    .seq_q      (seq_q),
    .gfx_ext_q  (gfx_ext_q),
    .depth_bpp  (depth_bpp),
    .row_dbl    (row_dbl),
    .write_mode (write_mode),
    .gfx_mode   (gfx_mode),
    .dac_ctrl   (dac_ctrl)
);

// File: tb/sim_pixdepth_sel.sv
module sim_pixdepth_sel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [2:0] acc_target = 3'd0;
    logic [7:0] acc_data = 8'd0;
    logic [5:0] depth_bpp;
    logic       row_dbl, read_mode, chain2_rd;
    logic [2:0] write_mode;
    logic [7:0] gfx_mode, dac_ctrl;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_seq, m_g5, m_gb, m_ctrl;
    logic [5:0] m_depth;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixdepth_sel u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_target(acc_target), .acc_data(acc_data), .depth_bpp(depth_bpp),
        .row_dbl(row_dbl), .read_mode(read_mode), .chain2_rd(chain2_rd),
        .write_mode(write_mode), .gfx_mode(gfx_mode), .dac_ctrl(dac_ctrl)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_depth(input logic [2:0] fmt, input logic b0,
                                             input logic [5:0] prev);
        if (fmt == 3'd0) return 6'd8;
        if (fmt == 3'd2) return 6'd24;
        if (fmt == 3'd4) return 6'd32;
        if (fmt == 3'd1 || fmt == 3'd3) return b0 ? 6'd16 : 6'd15;
        return prev;
    endfunction

    function automatic logic [2:0] exp_wmode(input logic [7:0] g5, input logic [7:0] gb);
        return gb[2] ? g5[2:0] : {1'b0, g5[1:0]};
    endfunction

    task automatic model_reset();
        m_seq = 0; m_g5 = 0; m_gb = 0; m_ctrl = 0; m_depth = 6'd8; m_cnt = 0;
    endtask

    task automatic model_step(input logic v, input logic w, input logic [2:0] t,
                              input logic [7:0] d);
        logic [7:0] o_seq, o_g5;
        logic       g5_written;
        o_seq = m_seq; o_g5 = m_g5; g5_written = 0;
        if (v) begin
            case (t)
                3'd0: if (w) m_seq = d;
                3'd1: if (w) begin m_g5 = d; g5_written = 1; end
                3'd2: if (w) m_gb = d;
                3'd3: begin
                    if (w) begin
                        if (m_cnt == 4) begin
                            m_ctrl  = d;
                            m_depth = exp_depth(o_seq[3:1], d[0], m_depth);
                        end
                        m_cnt = 0;
                    end else if (m_cnt < 4) m_cnt++;
                end
                3'd4: m_cnt = 0;
                default: ;
            endcase
        end
        if (!g5_written && o_seq[0] && o_g5[6:5] == 2'b00) m_g5 = 8'h60;
    endtask

    task automatic compare_all();
        check("R3/R4 dac_ctrl", int'(dac_ctrl), int'(m_ctrl));
        check("R5/R6/R7 depth_bpp", int'(depth_bpp), int'(m_depth));
        check("R8 gfx_mode", int'(gfx_mode), int'(m_g5));
        check("R9 row_dbl", int'(row_dbl), int'(m_seq[0] && m_depth == 6'd32));
        check("R10 write_mode", int'(write_mode), int'(exp_wmode(m_g5, m_gb)));
        check("R11 read_mode", int'(read_mode), int'(m_g5[3]));
        check("R11 chain2_rd", int'(chain2_rd), int'(m_g5[4]));
    endtask

    // one access per cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic acc(input logic v, input logic w, input logic [2:0] t, input logic [7:0] d);
        acc_valid = v; acc_write = w; acc_target = t; acc_data = d;
        @(posedge clk);
        model_step(v, w, t, d);
        @(negedge clk);
        acc_valid = 0;
        compare_all();
    endtask

    task automatic hidden_write(input logic [7:0] d);
        for (int i = 0; i < 4; i++) acc(1, 0, 3'd3, 8'h00);
        acc(1, 1, 3'd3, d);
    endtask

    initial begin
        int sel;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 depth", int'(depth_bpp), 8);
        check("R1 write_mode", int'(write_mode), 0);
        check("R1 read_mode", int'(read_mode), 0);
        check("R1 chain2_rd", int'(chain2_rd), 0);
        check("R1 row_dbl", int'(row_dbl), 0);
        check("R1 gfx_mode", int'(gfx_mode), 0);
        check("R1 dac_ctrl", int'(dac_ctrl), 0);

        // R3: three reads are not enough
        for (int i = 0; i < 3; i++) acc(1, 0, 3'd3, 8'h00);
        acc(1, 1, 3'd3, 8'h55);
        check("R3 short count", int'(dac_ctrl), 0);
        // R4: aux access clears count
        for (int i = 0; i < 3; i++) acc(1, 0, 3'd3, 8'h00);
        acc(1, 0, 3'd4, 8'h00);
        acc(1, 0, 3'd3, 8'h00);
        acc(1, 1, 3'd3, 8'h77);
        check("R4 aux clears", int'(dac_ctrl), 0);
        // R4: other registers do not clear; saturating count
        for (int i = 0; i < 2; i++) acc(1, 0, 3'd3, 8'h00);
        acc(1, 1, 3'd2, 8'h00);
        for (int i = 0; i < 4; i++) acc(1, 0, 3'd3, 8'h00);
        acc(1, 1, 3'd3, 8'h21);
        check("R4 non-DAC keeps count", int'(dac_ctrl), 8'h21);
        // R4: count back to 0 after hidden write
        acc(1, 1, 3'd3, 8'h99);
        check("R4 count cleared", int'(dac_ctrl), 8'h21);

        // R5/R6 each field code
        acc(1, 1, 3'd0, 8'h09);  // ext on, fmt 100
        hidden_write(8'h00);
        check("R5 depth 32", int'(depth_bpp), 32);
        check("R9 doubling", int'(row_dbl), 1);
        acc(1, 1, 3'd0, 8'h03);  // fmt 001
        check("R7 seq write alone", int'(depth_bpp), 32);
        hidden_write(8'h01);
        check("R6 dclk 16", int'(depth_bpp), 16);
        acc(1, 1, 3'd0, 8'h07);  // fmt 011
        hidden_write(8'h00);
        check("R6 15", int'(depth_bpp), 15);
        acc(1, 1, 3'd0, 8'h0B);  // fmt 101
        hidden_write(8'h01);
        check("R7 reserved hold", int'(depth_bpp), 15);
        acc(1, 1, 3'd0, 8'h05);  // fmt 010
        hidden_write(8'h00);
        check("R5 depth 24", int'(depth_bpp), 24);

        // R8 repair and R10 write mode
        acc(1, 1, 3'd1, 8'h1F);
        check("R8 written value visible", int'(gfx_mode), 8'h1F);
        acc(0, 0, 3'd0, 8'h00);
        check("R8 repaired", int'(gfx_mode), 8'h60);
        acc(1, 1, 3'd0, 8'h00);
        acc(1, 1, 3'd1, 8'h1F);
        acc(1, 1, 3'd2, 8'h04);
        check("R10 wide", int'(write_mode), 7);
        acc(1, 1, 3'd2, 8'h00);
        check("R10 narrow", int'(write_mode), 3);
        check("R11 chain2", int'(chain2_rd), 1);
        // R2: codes 5..7 do nothing
        acc(1, 1, 3'd5, 8'hFF);
        acc(1, 1, 3'd7, 8'hFF);
        check("R2 unused code", int'(gfx_mode), 8'h1F);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] t;
            sel = int'($urandom_range(0, 99));
            if (sel < 45)      t = 3'd3;
            else if (sel < 55) t = 3'd0;
            else if (sel < 67) t = 3'd1;
            else if (sel < 75) t = 3'd2;
            else if (sel < 82) t = 3'd4;
            else               t = 3'($urandom_range(5, 7));
            acc(($urandom_range(0, 9) != 0),
                (t == 3'd3) ? ($urandom_range(0, 5) == 0) : 1'($urandom_range(0, 1)),
                t, 8'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule